// File: doc/BRIEF.md
# Serial Clock-Calendar Register Bank (SPI Slave)

This block models the register side of a serial real-time clock as seen over a four-wire SPI link running in mode 3 (clock idles high, data captured on the rising edge, changed on the falling edge). The block holds seven calendar bytes, two four-byte alarm sets, a control byte, a read-only status byte, a trickle-charge byte and a small battery-backed scratch RAM. It does not advance time and does not compare alarms. Other logic, or software, reads and writes these registers over the serial link, which the block oversamples with its own system clock.

A frame opens when the active-high select rises. The first byte names the target. Its top bit chooses write (1) or read (0), and the lower seven bits give the starting index. Each data byte after it goes to, or comes from, the next index up. The index wraps from 0x7F back to 0x00, and dropping select closes the frame. A protect flag in the control byte blocks every write except one to control. That write can only change the flag, so clearing control fully takes two writes. Two parallel outputs show the control and seconds bytes for test.

Top module: `spi_rtc_regbank`

## Requirements
- R1: After reset, control (index 0x0F) holds 0x40 with protect set, every other register and RAM byte holds 0x00, and MISO is low.
- R2: The first byte of a frame is the command. Bit 7 = 1 selects write and bit 7 = 0 selects read. Bits 6:0 are the starting index, sent MSB first.
- R3: Within one frame, data byte k goes to, or comes from, the starting index plus k. Calendar bytes are at 0x00-0x06 in the order seconds, minutes, hours, weekday, date, month, year.
- R4: The running index wraps from 0x7F to 0x00 inside a burst.
- R5: While control bit 6 (protect) is 1, writes to any index other than 0x0F leave the target unchanged.
- R6: While protect is 1, a write to 0x0F changes only bit 6 and keeps bits 2:0. Writing 0x00 twice therefore first clears protect and then clears the remaining control bits.
- R7: While protect is 0, a write to 0x0F stores bits 6, 2, 1 and 0 of the data (the 1 Hz enable is bit 2 and the two alarm interrupt enables are bits 1:0). Control bits 7, 5, 4 and 3 always read 0.
- R8: Status (0x10) reads 0x00 and ignores writes. Indices 0x12-0x1F, and indices from 0x20+RAM_DEPTH to 0x7F, read 0x00 and ignore writes. Alarms occupy 0x07-0x0E, trickle charge is at 0x11, and RAM starts at 0x20.
- R9: MOSI is captured on rising SCK. MISO changes only after a falling SCK edge (or when select is low) and is stable while SCK is high.
- R10: Dropping select ends the frame at once. A partial data byte is discarded, and MISO is 0 while select is low.
- R11: tap_ctrl always shows the control register and tap_sec always shows the seconds register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce | input | 1 | Active-high chip select |
| sck | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| tap_ctrl | output | 8 | Parallel view of the control register |
| tap_sec | output | 8 | Parallel view of the seconds register |

## Verification
Bursts are run from several starting points. One covers the whole calendar group, one crosses from the alarm sets through control, status and trickle, one moves from the unmapped gap into RAM and back out of its top, and one crosses the 0x7F to 0x00 wrap. These show whether the index advances after each byte, and whether holes read zero without being mapped onto real storage. Control is exercised with protect set and protect clear, with an all-ones write and with the two-step clear, which separates the flag-only path from the masked full write. A frame cut off mid-byte, and writes made after protect is set again, show that discarded data never lands.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;
   localparam int ADDR_W   = 7;
   localparam int DATA_W   = 8;
   localparam int FILE_N   = 18;          // indices 0x00..0x11
   localparam int FILE_AW  = $clog2(FILE_N);
   localparam int RAM_BASE = 32;          // scratch RAM origin
   localparam int IDX_SEC  = 0;
   localparam int IDX_CTRL = 15;
   localparam int IDX_STAT = 16;
   localparam int WP_BIT   = 6;

   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [DATA_W-1:0] byte_t;

   localparam byte_t CTRL_KEEP  = 8'h47;  // bits that exist in control
   localparam byte_t CTRL_RESET = 8'h40;  // protect set out of reset
endpackage

// File: rtl/spi_rtc_sync.sv
module spi_rtc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce,
   input  logic sck,
   input  logic mosi,
   output logic ce_s,
   output logic mosi_s,
   output logic sck_rise,
   output logic sck_fall
);
   localparam int NSIG = 3;
   localparam logic [NSIG-1:0] IDLE = 3'b001;   // sck idles high

   logic [NSIG-1:0] raw, synced;
   logic            sck_d;

   assign raw = {ce, mosi, sck};

   generate
      if (STAGES < 1) begin : g_bad
         $error("spi_rtc_sync: STAGES must be at least 1");
      end
      for (genvar g = 0; g < NSIG; g++) begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {STAGES{IDLE[g]}};
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
         end
         assign synced[g] = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b1;
      else        sck_d <= synced[0];
   end

   assign ce_s     = synced[2];
   assign mosi_s   = synced[1];
   assign sck_rise =  synced[0] & ~sck_d;
   assign sck_fall = ~synced[0] &  sck_d;
endmodule

// File: rtl/spi_rtc_frame.sv
module spi_rtc_frame
   import spi_rtc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ce_s,
   input  logic  mosi_s,
   input  logic  sck_rise,
   input  logic  sck_fall,
   input  byte_t rd_data,
   output addr_t cur_addr,
   output logic  wr_en,
   output addr_t wr_addr,
   output byte_t wr_data,
   output logic  data_done,
   output logic  miso
);
   logic [2:0]        bit_cnt;
   logic              in_data, is_wr;
   logic [DATA_W-2:0] rx_sh;
   byte_t             tx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         in_data   <= 1'b0;
         is_wr     <= 1'b0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         cur_addr  <= '0;
         wr_en     <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         data_done <= 1'b0;
         miso      <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         data_done <= 1'b0;
         if (!ce_s) begin
            bit_cnt <= '0;
            in_data <= 1'b0;
            is_wr   <= 1'b0;
            miso    <= 1'b0;
         end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            rx_sh   <= {rx_sh[DATA_W-3:0], mosi_s};
            if (bit_cnt == 3'd7) begin
               if (!in_data) begin
                  in_data  <= 1'b1;
                  is_wr    <= rx_sh[DATA_W-2];
                  cur_addr <= {rx_sh[ADDR_W-2:0], mosi_s};
               end else begin
                  if (is_wr) begin
                     wr_en   <= 1'b1;
                     wr_addr <= cur_addr;
                     wr_data <= {rx_sh, mosi_s};
                  end
                  cur_addr  <= cur_addr + addr_t'(1);
                  data_done <= 1'b1;
               end
            end
         end else if (sck_fall) begin
            if (bit_cnt == 3'd0) begin
               if (in_data && !is_wr) begin
                  miso  <= rd_data[DATA_W-1];
                  tx_sh <= {rd_data[DATA_W-2:0], 1'b0};
               end else begin
                  miso  <= 1'b0;
                  tx_sh <= '0;
               end
            end else begin
               miso  <= tx_sh[DATA_W-1];
               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs
   import spi_rtc_pkg::*;
#(
   parameter int RAM_DEPTH = 32
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_en,
   input  addr_t wr_addr,
   input  byte_t wr_data,
   input  addr_t rd_addr,
   output byte_t rd_data,
   output byte_t ctrl_o,
   output byte_t sec_o
);
   localparam int RAM_AW  = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
   localparam int RAM_TOP = RAM_BASE + RAM_DEPTH;

   generate
      if (RAM_DEPTH < 1 || RAM_TOP > (1 << ADDR_W)) begin : g_bad
         $error("spi_rtc_regs: RAM_DEPTH does not fit the index space");
      end
   endgenerate

   byte_t file_q [FILE_N];
   byte_t ram_q  [RAM_DEPTH];
   logic  wp;
   addr_t wr_off, rd_off;
   logic  wr_ram, rd_ram;

   assign wp     = file_q[IDX_CTRL][WP_BIT];
   assign wr_off = wr_addr - addr_t'(RAM_BASE);
   assign rd_off = rd_addr - addr_t'(RAM_BASE);
   assign wr_ram = (int'(wr_addr) >= RAM_BASE) && (int'(wr_addr) < RAM_TOP);
   assign rd_ram = (int'(rd_addr) >= RAM_BASE) && (int'(rd_addr) < RAM_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < FILE_N; i++)
            file_q[i] <= (i == IDX_CTRL) ? CTRL_RESET : '0;
      end else if (wr_en) begin
         for (int i = 0; i < FILE_N; i++) begin
            if (int'(wr_addr) == i) begin
               if (i == IDX_CTRL) begin
                  if (wp) file_q[i][WP_BIT] <= wr_data[WP_BIT];
                  else    file_q[i]         <= wr_data & CTRL_KEEP;
               end else if (i != IDX_STAT && !wp) begin
                  file_q[i] <= wr_data;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
      end else if (wr_en && wr_ram && !wp) begin
         ram_q[wr_off[RAM_AW-1:0]] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(rd_addr) < FILE_N) rd_data = file_q[rd_addr[FILE_AW-1:0]];
      else if (rd_ram)            rd_data = ram_q[rd_off[RAM_AW-1:0]];
   end

   assign ctrl_o = file_q[IDX_CTRL];
   assign sec_o  = file_q[IDX_SEC];
endmodule

// File: rtl/spi_rtc_regbank.sv
module spi_rtc_regbank
   import spi_rtc_pkg::*;
#(
   parameter int RAM_DEPTH   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ce,
   input  logic       sck,
   input  logic       mosi,
   output logic       miso,
   output logic [7:0] tap_ctrl,
   output logic [7:0] tap_sec
);
   logic  ce_s, mosi_s, sck_rise, sck_fall;
   logic  wr_en, data_done;
   addr_t cur_addr, wr_addr;
   byte_t wr_data, rd_data;

   spi_rtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .mosi(mosi),
      .ce_s(ce_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
   );

   spi_rtc_frame u_frame (
      .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .mosi_s(mosi_s),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .rd_data(rd_data),
      .cur_addr(cur_addr), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .data_done(data_done), .miso(miso)
   );

   spi_rtc_regs #(.RAM_DEPTH(RAM_DEPTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(cur_addr), .rd_data(rd_data),
      .ctrl_o(tap_ctrl), .sec_o(tap_sec)
   );
endmodule

// File: rtl/spi_rtc_regbank_chk.sv
module spi_rtc_regbank_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ce_s,
   input logic       sck_fall,
   input logic       miso,
   input logic       wr_en,
   input logic [6:0] wr_addr,
   input logic       data_done,
   input logic [6:0] cur_addr,
   input logic [7:0] tap_ctrl,
   input logic [7:0] tap_sec
);
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      data_done |-> cur_addr == 7'($past(cur_addr) + 7'd1)); // R3

   AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tap_ctrl[6] && wr_addr != 7'h0F) |=> $stable(tap_sec)); // R5

   AST_WP_CTRL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && tap_ctrl[6] && wr_addr == 7'h0F) |=> tap_ctrl[2:0] == $past(tap_ctrl[2:0])); // R6

   AST_CTRL_HOLES: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_ctrl & 8'hB8) == 8'h00); // R7

   AST_MISO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(miso) |-> ($past(sck_fall) || !$past(ce_s))); // R9

   AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_s |=> !miso); // R10
endmodule

bind spi_rtc_regbank spi_rtc_regbank_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ce_s(ce_s), .sck_fall(sck_fall), .miso(miso),
   .wr_en(wr_en), .wr_addr(wr_addr), .data_done(data_done),
   .cur_addr(cur_addr), .tap_ctrl(tap_ctrl), .tap_sec(tap_sec)
);

// File: tb/sim_spi_rtc_regbank.sv
`timescale 1ns/1ps
module sim_spi_rtc_regbank;
   localparam int RAM_DEPTH = 32;
   localparam int HALF      = 8;

   logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sck = 1'b1, mosi = 1'b0;
   logic miso;
   logic [7:0] tap_ctrl, tap_sec;

   always #2.5 clk = ~clk;

   spi_rtc_regbank #(.RAM_DEPTH(RAM_DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .mosi(mosi),
      .miso(miso), .tap_ctrl(tap_ctrl), .tap_sec(tap_sec)
   );

   int compared = 0, mismatched = 0, r9_bad = 0;
   bit done = 1'b0;
   logic [7:0] mdl [128];
   logic [7:0] exp_q [$];
   logic [7:0] got_q [$];
   string      tag_q [$];

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      compared++;
      if (got !== exp) begin
         mismatched++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   function automatic bit mapped(input int a);
      return (a <= 17 && a != 16) || (a >= 32 && a < 32 + RAM_DEPTH);
   endfunction

   task automatic mdl_wr(input int a, input logic [7:0] v);
      if (a == 15) begin
         if (mdl[15][6]) mdl[15][6] = v[6];
         else            mdl[15] = v & 8'h47;
      end else if (!mdl[15][6] && mapped(a)) mdl[a] = v;
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         sck = 1'b0; mosi = tx[i];
         tick(HALF);
         rx[i] = miso;
         sck = 1'b1;
         tick(HALF / 2);
         if (miso !== rx[i]) r9_bad++;
         tick(HALF - HALF / 2);
      end
   endtask

   task automatic wr_burst(input int a, input logic [7:0] d[$]);
      logic [7:0] r;
      ce = 1'b1; tick(HALF);
      spi_byte({1'b1, 7'(a)}, r);
      foreach (d[k]) begin
         spi_byte(d[k], r);
         mdl_wr((a + k) % 128, d[k]);
      end
      tick(HALF); ce = 1'b0; tick(4 * HALF);
   endtask

   task automatic rd_burst(input int a, input int n, input string tag);
      logic [7:0] r;
      ce = 1'b1; tick(HALF);
      spi_byte({1'b0, 7'(a)}, r);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(mdl[(a + k) % 128]);
         tag_q.push_back(tag);
         spi_byte(8'h00, r);
         got_q.push_back(r);
      end
      tick(HALF); ce = 1'b0; tick(4 * HALF);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (got_q.size() > 0 && exp_q.size() > 0) begin
            automatic logic [7:0] g = got_q.pop_front();
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string      t = tag_q.pop_front();
            check(t, g, e);
         end
      end
   end

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++; mismatched++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
      mdl[15] = 8'h40;
      tick(10); rst_n = 1'b1; tick(4);

      check("R1 tap_ctrl", tap_ctrl, 8'h40);
      check("R1 tap_sec", tap_sec, 8'h00);
      check("R1 miso", {7'd0, miso}, 8'h00);
      rd_burst(15, 3, "R1 R2 read after reset");

      wr_burst(0, '{8'h11, 8'h22, 8'h33});
      rd_burst(0, 3, "R5 protected calendar");

      wr_burst(15, '{8'h00});
      check("R6 first clear", tap_ctrl, 8'h00);
      wr_burst(15, '{8'hFF});
      check("R7 masked control", tap_ctrl, 8'h47);
      wr_burst(15, '{8'h00});
      check("R6 step one keeps low bits", tap_ctrl, 8'h07);
      wr_burst(15, '{8'h00});
      check("R6 step two", tap_ctrl, 8'h00);

      wr_burst(0, '{8'h45, 8'h30, 8'h12, 8'h03, 8'h28, 8'h02, 8'h24});
      rd_burst(0, 7, "R3 calendar burst");
      check("R11 tap_sec", tap_sec, 8'h45);

      wr_burst(11, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h04, 8'h55, 8'hA5});
      rd_burst(7, 11, "R8 alarms control status trickle");
      check("R11 tap_ctrl", tap_ctrl, 8'h04);

      wr_burst(32, '{8'hDE, 8'hAD, 8'hBE, 8'hEF});
      rd_burst(30, 8, "R8 gap into RAM");
      wr_burst(62, '{8'h71, 8'h72, 8'h73});
      rd_burst(62, 3, "R8 RAM top");
      wr_burst(18, '{8'h66});
      rd_burst(18, 1, "R8 hole write");

      wr_burst(126, '{8'hAA, 8'hBB, 8'h5C});
      rd_burst(127, 2, "R4 wrap");
      check("R4 tap_sec after wrap", tap_sec, 8'h5C);

      // cut frame mid data byte
      ce = 1'b1; tick(HALF);
      spi_byte(8'h80, r);
      for (int i = 7; i >= 4; i--) begin
         sck = 1'b0; mosi = 1'b1; tick(HALF);
         sck = 1'b1; tick(HALF);
      end
      ce = 1'b0; tick(4 * HALF);
      check("R10 partial byte dropped", tap_sec, 8'h5C);
      check("R10 miso idle", {7'd0, miso}, 8'h00);
      rd_burst(0, 1, "R10 seconds after cut");

      wr_burst(15, '{8'h40});
      check("R7 protect set", tap_ctrl, 8'h40);
      wr_burst(32, '{8'h99});
      rd_burst(32, 1, "R5 protected RAM");
      wr_burst(0, '{8'h01});
      check("R5 protected seconds", tap_sec, 8'h5C);

      check("R9 miso steady while sck high", 8'(r9_bad), 8'h00);

      tick(20);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule